// File: doc/BRIEF.md
# Detection Window Centering Sequencer

This block centres a data-detection window without outside help. The window has a signed offset of -15 to +15 steps. After a start pulse the block searches in two directions. It first moves the offset early, one step at a time, until an external error counter reports a count at or above a programmed threshold. It records that offset and then runs the same search in the late direction. It then loads the midpoint of the two recorded offsets, which cancels the skew of the window.

Each offset goes to a serial offset-register writer through a load request and acknowledge. The block raises a request only while the read gate is low. After every acknowledged offset change, the block waits a programmable number of clock cycles so that the analog loop can settle. It then asks the error source for a measurement through a start/done handshake. The stored endpoints and the saturation flags stay visible on the outputs once the run is over.

Top module: `win_center_seq`

## Requirements
- R1: After reset, busy_o, done_o, ofs_load_o and meas_start_o are low, and the block waits in idle for start_i.
- R2: After start, the first offset loaded is 0. The early sweep then steps the offset by -1 per measurement (0, -1, -2, ...) before any positive offset is loaded.
- R3: A sweep stops at the first offset whose measured error count is greater than or equal to err_thresh_i. That offset is stored (early_pt_o for the early sweep).
- R4: The late sweep restarts at 0 and steps by +1. Its stopping offset is stored in late_pt_o.
- R5: If a sweep reaches -15 (early) or +15 (late) without meeting the threshold, that limit is stored as the endpoint and sat_early_o or sat_late_o is set.
- R6: The final offset is (early + late) arithmetically shifted right by one, which rounds toward negative infinity. It is loaded as the last offset of the run. For a symmetric error profile that does not saturate, it equals the negative of the window skew to within one step.
- R7: ofs_load_o is never high while read_gate_i is high. A request is held off until the gate drops.
- R8: meas_start_o is not raised until at least settle_cycles_i clock cycles after the acknowledge of the preceding offset load.
- R9: meas_start_o is a single-cycle pulse. The block waits for meas_done_i and samples err_count_i in that cycle.
- R10: busy_o is high from the cycle after start_i until the final load is acknowledged. done_o then pulses for one cycle with busy_o low.
- R11: ofs_value_o stays within -15..+15 whenever ofs_load_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a centering run when idle |
| read_gate_i | input | 1 | Read active; blocks offset loads while high |
| err_thresh_i | input | CNT_W | Error count that ends a sweep |
| settle_cycles_i | input | SET_W | Settling wait after each offset change, in cycles |
| meas_start_o | output | 1 | One-cycle request for an error measurement |
| meas_done_i | input | 1 | Measurement complete; err_count_i valid |
| err_count_i | input | CNT_W | Measured error count |
| ofs_load_o | output | 1 | Request to write ofs_value_o into the offset register |
| ofs_value_o | output | OFS_W | Signed window offset, two's complement |
| ofs_ack_i | input | 1 | Offset write accepted |
| early_pt_o | output | OFS_W | Stored early endpoint (signed) |
| late_pt_o | output | OFS_W | Stored late endpoint (signed) |
| sat_early_o | output | 1 | Early sweep hit -15 without reaching the threshold |
| sat_late_o | output | 1 | Late sweep hit +15 without reaching the threshold |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The hardest cases to reach are a sweep that runs out of range, and a midpoint whose sum is odd, where rounding toward negative infinity shows. The bench reaches both by modelling an error source with a hidden skew that the block cannot see, and a V-shaped error count around it. Large skews combined with a high threshold push one sweep into saturation and give an odd endpoint sum of either sign. A separate run holds the read gate high across start to show that load requests are held off.

// File: rtl/win_center_pkg.sv
package win_center_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_MREQ,
    ST_MWAIT,
    ST_EVAL
  } wc_state_e;

  typedef enum logic [1:0] {
    PH_EARLY,
    PH_LATE,
    PH_FINAL
  } wc_phase_e;
endpackage

// File: rtl/wc_settle_timer.sv
module wc_settle_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] cycles_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= cycles_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/wc_midpoint.sv
module wc_midpoint #(
  parameter int W = 5
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] mid_o
);
  logic signed [W:0] sum;

  always_comb begin
    sum   = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    mid_o = sum[W:1];  // arithmetic shift by one: floor
  end
endmodule

// File: rtl/win_center_seq.sv
module win_center_seq
  import win_center_pkg::*;
#(
  parameter int OFS_W   = 5,
  parameter int OFS_MAX = 15,
  parameter int CNT_W   = 8,
  parameter int SET_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             read_gate_i,
  input  logic [CNT_W-1:0] err_thresh_i,
  input  logic [SET_W-1:0] settle_cycles_i,
  output logic             meas_start_o,
  input  logic             meas_done_i,
  input  logic [CNT_W-1:0] err_count_i,
  output logic             ofs_load_o,
  output logic [OFS_W-1:0] ofs_value_o,
  input  logic             ofs_ack_i,
  output logic [OFS_W-1:0] early_pt_o,
  output logic [OFS_W-1:0] late_pt_o,
  output logic             sat_early_o,
  output logic             sat_late_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic signed [OFS_W-1:0] OFS_HI = OFS_W'(OFS_MAX);
  localparam logic signed [OFS_W-1:0] OFS_LO = -OFS_HI;
  localparam logic signed [OFS_W-1:0] ONE    = OFS_W'(1);

  wc_state_e               state_q;
  wc_phase_e               phase_q;
  logic signed [OFS_W-1:0] cur_q, early_q, late_q, mid;
  logic [CNT_W-1:0]        err_q;
  logic                    sat_e_q, sat_l_q, done_q;
  logic                    ack_take, settled, hit;

  assign ofs_load_o   = (state_q == ST_LOAD) && !read_gate_i;
  assign ack_take     = ofs_load_o && ofs_ack_i;
  assign meas_start_o = (state_q == ST_MREQ);
  assign hit          = (err_q >= err_thresh_i);

  wc_settle_timer #(.W(SET_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ack_take),
    .cycles_i  (settle_cycles_i),
    .expired_o (settled)
  );

  wc_midpoint #(.W(OFS_W)) u_mid (
    .a_i   (early_q),
    .b_i   (cur_q),
    .mid_o (mid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= PH_EARLY;
      cur_q   <= '0;
      early_q <= '0;
      late_q  <= '0;
      err_q   <= '0;
      sat_e_q <= 1'b0;
      sat_l_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          phase_q <= PH_EARLY;
          cur_q   <= '0;
          sat_e_q <= 1'b0;
          sat_l_q <= 1'b0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: if (ack_take) begin
          if (phase_q == PH_FINAL) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: if (settled) state_q <= ST_MREQ;
        ST_MREQ:   state_q <= ST_MWAIT;
        ST_MWAIT: if (meas_done_i) begin
          err_q   <= err_count_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          state_q <= ST_LOAD;
          if (phase_q == PH_EARLY) begin
            if (hit || cur_q == OFS_LO) begin
              early_q <= cur_q;
              sat_e_q <= !hit;
              phase_q <= PH_LATE;
              cur_q   <= '0;
            end else begin
              cur_q <= cur_q - ONE;
            end
          end else begin
            if (hit || cur_q == OFS_HI) begin
              late_q  <= cur_q;
              sat_l_q <= !hit;
              phase_q <= PH_FINAL;
              cur_q   <= mid;
            end else begin
              cur_q <= cur_q + ONE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ofs_value_o = cur_q;
  assign early_pt_o  = early_q;
  assign late_pt_o   = late_q;
  assign sat_early_o = sat_e_q;
  assign sat_late_o  = sat_l_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  // Cycles elapsed since the last accepted offset write (checker state).
  logic [SET_W:0] since_ack_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   since_ack_q <= '0;
    else if (ack_take)             since_ack_q <= '0;
    else if (!(&since_ack_q))      since_ack_q <= since_ack_q + 1'b1;
  end

  a_r7_no_load_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_load_o |-> !read_gate_i);

  a_r8_settle_before_meas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_start_o |-> (since_ack_q >= {1'b0, settle_cycles_i}));

  a_r9_meas_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_start_o |=> !meas_start_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r11_ofs_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_load_o |-> ($signed(ofs_value_o) <= OFS_HI && $signed(ofs_value_o) >= OFS_LO));
endmodule

// File: tb/win_center_seq_bench.sv
module win_center_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    int skew; int thr; int settle; int e; int l; int f; bit se; bit sl;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{ 3,  20,  5,  -8,  2, -3, 1'b0, 1'b0},
    '{-4,  28,  0,  -3, 11,  4, 1'b0, 1'b0},
    '{ 0,   8, 40,  -2,  2,  0, 1'b0, 1'b0},
    '{10,  60,  3, -15,  5, -5, 1'b1, 1'b0},
    '{ 0, 100,  1, -15, 15,  0, 1'b1, 1'b1},
    '{ 9,  60,  2, -15,  6, -5, 1'b1, 1'b0},
    '{-9,  60,  2,  -6, 15,  4, 1'b0, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic start = 0, gate = 0, mdone = 0, ack = 0;
  logic [7:0] thr = 0, errc = 0;
  logic [15:0] settle = 0;
  logic mstart, load, sat_e, sat_l, busy, done;
  logic [4:0] ofs, e_pt, l_pt;

  int checks = 0, fails = 0;
  int skew = 0, applied = 0, since_ack = 0, mcount = 0;
  int load_cnt = 0, gate_viol = 0, settle_viol = 0;
  int seq0 = 99, seq1 = 99;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_center_seq u_win_center_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .read_gate_i(gate),
    .err_thresh_i(thr), .settle_cycles_i(settle),
    .meas_start_o(mstart), .meas_done_i(mdone), .err_count_i(errc),
    .ofs_load_o(load), .ofs_value_o(ofs), .ofs_ack_i(ack),
    .early_pt_o(e_pt), .late_pt_o(l_pt), .sat_early_o(sat_e), .sat_late_o(sat_l),
    .busy_o(busy), .done_o(done)
  );

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offset writer and error source with a hidden skew.
  initial begin
    forever begin
      @(negedge clk);
      ack = 0; mdone = 0;
      if (load) begin
        if (gate) gate_viol++;
        ack = 1;
        applied = $signed(ofs);
        if (load_cnt == 0) seq0 = applied;
        if (load_cnt == 1) seq1 = applied;
        load_cnt++;
        since_ack = 0;
      end else begin
        since_ack++;
      end
      if (mstart) begin
        if (since_ack < int'(settle)) settle_viol++;
        mcount = 2;
      end else if (mcount > 0) begin
        mcount--;
        if (mcount == 0) begin
          mdone = 1;
          errc = 8'(absv(applied + skew) * 4);
        end
      end
    end
  end

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic run_case(input vec_t v, input bit hold_gate);
    bit ok;
    skew = v.skew; thr = 8'(v.thr); settle = 16'(v.settle);
    load_cnt = 0; gate_viol = 0; settle_viol = 0;
    gate = hold_gate;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    if (hold_gate) begin
      repeat (20) begin
        @(negedge clk);
        if (load) break;
      end
      chk(load == 1'b0 && load_cnt == 0, "R7 load held off by gate", load_cnt, 0);
      chk(busy == 1'b1, "R7 still busy while gated", int'(busy), 1);
      gate = 0;
    end
    wait_done(ok);
    chk(ok, "R10 run completes with done", int'(ok), 1);
    chk(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
    chk(seq0 == 0, "R2 first load is zero", seq0, 0);
    chk(seq1 == -1, "R2 second load steps early", seq1, -1);
    chk($signed(e_pt) == v.e, "R3 early endpoint", $signed(e_pt), v.e);
    chk($signed(l_pt) == v.l, "R4 late endpoint", $signed(l_pt), v.l);
    chk(sat_e == v.se && sat_l == v.sl, "R5 saturation flags",
        int'({sat_e, sat_l}), int'({v.se, v.sl}));
    chk(applied == v.f, "R6 final offset loaded", applied, v.f);
    if (!v.se && !v.sl)
      chk(absv(applied + v.skew) <= 1, "R6 skew cancelled", applied, -v.skew);
    chk(gate_viol == 0, "R7 no load while read gate high", gate_viol, 0);
    chk(settle_viol == 0, "R8 settle interval honoured", settle_viol, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done is one cycle", int'(done), 0);
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && load == 0 && mstart == 0, "R1 reset outputs",
        int'({busy, done, load, mstart}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 idle without start", int'(busy), 0);

    for (int k = 0; k < NV; k++) run_case(VECS[k], 1'b0);

    // R7: read gate high across start.
    run_case(VECS[0], 1'b1);

    // R9: measurement waits for done; no second request while waiting.
    skew = 0; thr = 8'd8; settle = 16'd0; load_cnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mstart) break;
    end
    @(negedge clk);
    chk(mstart == 1'b0, "R9 request is a single pulse", int'(mstart), 1'b0);

    // R1: reset in the middle of a run.
    rst_n = 0;
    @(negedge clk);
    chk(busy == 0 && load == 0 && mstart == 0, "R1 reset mid run",
        int'({busy, load, mstart}), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 stays idle after reset", int'(busy), 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule